// File: doc/BRIEF.md
# Transmit Frame Sync Source Selector

This block chooses where the transmit frame synchronization of a buffered serial port comes from. It also sets the polarity of that signal and decides whether the frame-sync pad is an input or an output. There are three sources. The first is the pad itself, used as an input. The second is the frame pulse from a sample rate generator. The third is a pulse one bit clock wide, made inside the block each time the transmit data register is copied into the shift register. The chosen signal goes to the transmit shifter as an active-high internal frame sync. In the two internal modes it is also driven out on the pad, with the polarity applied.

A second path carries the selected frame sync into the CPU clock domain. There it raises a one-cycle interrupt pulse at the start of each frame, but only when the interrupt mode field selects frame detection. This path ignores the transmitter reset. Software can therefore wait for a real frame boundary before it releases the transmitter, with the same source and polarity settings already in force.

Top module: `fsx_frame_sync_sel`

## Requirements
- R1: With `mode_int_i`=0 the pad is an input (`pad_oe_o`=0), `pad_o` is driven 0, and the internal frame sync equals `pad_i` XOR `pol_i`.
- R2: With `mode_int_i`=1 and `gen_sel_i`=1 the pad is an output, the internal frame sync equals `gen_fs_i` while `fgen_rst_ni`=1, and `pad_o` equals the internal frame sync XOR `pol_i`.
- R3: In generator mode with `fgen_rst_ni`=0 the internal frame sync stays 0 and `pad_o` stays equal to `pol_i`.
- R4: With `mode_int_i`=1 and `gen_sel_i`=0, a `copy_req_i` sampled high by a bit-clock edge while no copy pulse is active makes the copy pulse high for exactly the following bit-clock period. The pad is an output and carries the pulse XOR `pol_i`.
- R5: The copy pulse is never high for two bit-clock periods in a row. A request that arrives while a pulse is high is held and produces a second one-period pulse after one low period.
- R6: While `tx_rst_ni`=0, `fs_tx_o` is held 0 in every mode. While `tx_rst_ni`=1, `fs_tx_o` equals the internal frame sync.
- R7: With `irq_mode_i`=2'b10, every rising edge of the selected internal frame sync produces exactly one `irq_o` pulse, one CPU clock wide, after a two-flop synchronizer and an edge detector in the CPU domain.
- R8: With `irq_mode_i` set to 2'b00, 2'b01 or 2'b11, `irq_o` stays 0 whatever frame syncs occur.
- R9: The interrupt of R7 is produced while `tx_rst_ni`=0, with source and polarity selection still applied.
- R10: While `rst_ni`=0, `fs_tx_o`, `irq_o` and the copy pulse are 0, and copy requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Serial bit clock |
| cpu_clk_i | input | 1 | CPU clock for the interrupt path |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| tx_rst_ni | input | 1 | Transmitter reset, active low; gates only `fs_tx_o` |
| fgen_rst_ni | input | 1 | Frame generator enable (0 = generator held in reset) |
| mode_int_i | input | 1 | 0: pad input source; 1: internal source, pad output |
| gen_sel_i | input | 1 | In internal mode, 1: generator pulse, 0: copy pulse |
| pol_i | input | 1 | 1 inverts between pad and internal frame sync |
| irq_mode_i | input | 2 | Interrupt mode; 2'b10 selects frame detect |
| pad_i | input | 1 | Frame-sync pad input value |
| gen_fs_i | input | 1 | Sample rate generator frame pulse, bit-clock domain |
| copy_req_i | input | 1 | Data-to-shift-register copy event, bit-clock domain |
| pad_o | output | 1 | Frame-sync pad output value |
| pad_oe_o | output | 1 | Pad output enable |
| fs_tx_o | output | 1 | Active-high internal frame sync to the shifter |
| irq_o | output | 1 | Frame-detect interrupt pulse, CPU domain |

## Verification
A wrong source or polarity decode shows up at `pad_o`, `pad_oe_o` and `fs_tx_o` in the same bit-clock period. The bench sweeps every combination of the static selects against the pad and generator inputs. A copy-pulse state machine that sticks, drops a queued request or doubles a pulse is seen at the first bit-clock edge after the request. A broken synchronizer, a broken edge detector or a wrong mode gate shows as a missing, extra or stretched interrupt within about four CPU cycles of a frame edge. The bench counts interrupt pulses against the known frame count in each source, polarity, interrupt-mode and transmitter-reset setting.

// File: rtl/fsx_pkg.sv
package fsx_pkg;
  localparam int IRQ_MODE_W = 2;

  typedef enum logic [IRQ_MODE_W-1:0] {
    IRQ_M0    = 2'b00,
    IRQ_M1    = 2'b01,
    IRQ_FRAME = 2'b10,
    IRQ_M3    = 2'b11
  } irq_mode_e;

  typedef enum logic [1:0] {
    SRC_PAD  = 2'b00,
    SRC_GEN  = 2'b01,
    SRC_COPY = 2'b10
  } fs_src_e;

  function automatic fs_src_e decode_src(input logic mode_int, input logic gen_sel);
    if (!mode_int) return SRC_PAD;
    return gen_sel ? SRC_GEN : SRC_COPY;
  endfunction
endpackage

// File: rtl/fsx_copy_pulse.sv
module fsx_copy_pulse (
  input  logic bclk_i,
  input  logic rst_ni,
  input  logic copy_req_i,
  output logic pulse_o
);
  logic pulse_q, pend_q;

  always_ff @(posedge bclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      // one period high, never back-to-back; a request during a pulse waits one slot
      pulse_q <= (copy_req_i | pend_q) & ~pulse_q;
      pend_q  <= pulse_q ? (pend_q | copy_req_i) : 1'b0;
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/fsx_src_mux.sv
module fsx_src_mux
  import fsx_pkg::*;
(
  input  logic mode_int_i,
  input  logic gen_sel_i,
  input  logic pol_i,
  input  logic fgen_rst_ni,
  input  logic pad_i,
  input  logic gen_fs_i,
  input  logic copy_pulse_i,
  output logic fs_sel_o,
  output logic pad_o,
  output logic pad_oe_o
);
  fs_src_e src;

  always_comb begin
    src = decode_src(mode_int_i, gen_sel_i);
    unique case (src)
      SRC_PAD:  fs_sel_o = pad_i ^ pol_i;
      SRC_GEN:  fs_sel_o = gen_fs_i & fgen_rst_ni;
      SRC_COPY: fs_sel_o = copy_pulse_i;
      default:  fs_sel_o = 1'b0;
    endcase
    pad_oe_o = (src != SRC_PAD);
    pad_o    = pad_oe_o ? (fs_sel_o ^ pol_i) : 1'b0;
  end
endmodule

// File: rtl/fsx_irq_sync.sv
module fsx_irq_sync
  import fsx_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic                  cpu_clk_i,
  input  logic                  rst_ni,
  input  logic                  fs_i,
  input  logic [IRQ_MODE_W-1:0] irq_mode_i,
  output logic                  irq_o
);
  localparam int HIST = STAGES;  // index of the edge-history flop

  logic [HIST:0] sync_q;
  logic          irq_q;
  logic          edge_seen;

  always_ff @(posedge cpu_clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[HIST-1:0], fs_i};
  end

  assign edge_seen = sync_q[HIST-1] & ~sync_q[HIST];

  always_ff @(posedge cpu_clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= edge_seen & (irq_mode_i == IRQ_FRAME);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/fsx_frame_sync_sel.sv
module fsx_frame_sync_sel
  import fsx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  bclk_i,
  input  logic                  cpu_clk_i,
  input  logic                  rst_ni,
  input  logic                  tx_rst_ni,
  input  logic                  fgen_rst_ni,
  input  logic                  mode_int_i,
  input  logic                  gen_sel_i,
  input  logic                  pol_i,
  input  logic [IRQ_MODE_W-1:0] irq_mode_i,
  input  logic                  pad_i,
  input  logic                  gen_fs_i,
  input  logic                  copy_req_i,
  output logic                  pad_o,
  output logic                  pad_oe_o,
  output logic                  fs_tx_o,
  output logic                  irq_o
);
  logic copy_pulse;
  logic fs_sel;
  logic fs_src_q;

  fsx_copy_pulse u_copy (
    .bclk_i    (bclk_i),
    .rst_ni    (rst_ni),
    .copy_req_i(copy_req_i),
    .pulse_o   (copy_pulse)
  );

  fsx_src_mux u_mux (
    .mode_int_i  (mode_int_i),
    .gen_sel_i   (gen_sel_i),
    .pol_i       (pol_i),
    .fgen_rst_ni (fgen_rst_ni),
    .pad_i       (pad_i),
    .gen_fs_i    (gen_fs_i),
    .copy_pulse_i(copy_pulse),
    .fs_sel_o    (fs_sel),
    .pad_o       (pad_o),
    .pad_oe_o    (pad_oe_o)
  );

  assign fs_tx_o = fs_sel & tx_rst_ni & rst_ni;

  // launch flop for the crossing; independent of the transmitter reset
  always_ff @(posedge bclk_i or negedge rst_ni) begin
    if (!rst_ni) fs_src_q <= 1'b0;
    else         fs_src_q <= fs_sel;
  end

  fsx_irq_sync #(.STAGES(SYNC_STAGES)) u_irq (
    .cpu_clk_i (cpu_clk_i),
    .rst_ni    (rst_ni),
    .fs_i      (fs_src_q),
    .irq_mode_i(irq_mode_i),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/fsx_frame_sync_sel_chk.sv
module fsx_frame_sync_sel_chk
  import fsx_pkg::*;
(
  input logic                  bclk_i,
  input logic                  cpu_clk_i,
  input logic                  rst_ni,
  input logic                  mode_int_i,
  input logic                  gen_sel_i,
  input logic                  fgen_rst_ni,
  input logic                  pol_i,
  input logic                  pad_o,
  input logic                  copy_req_i,
  input logic                  copy_pulse,
  input logic [IRQ_MODE_W-1:0] irq_mode_i,
  input logic                  irq_o
);
  // R4
  copy_fires_chk: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    (copy_req_i && !copy_pulse) |=> copy_pulse);

  // R5
  copy_single_chk: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    copy_pulse |=> !copy_pulse);

  // R3
  gen_off_pad_chk: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    (mode_int_i && gen_sel_i && !fgen_rst_ni) |-> (pad_o == pol_i));

  // R7
  irq_width_chk: assert property (@(posedge cpu_clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  // R8
  irq_gate_chk: assert property (@(posedge cpu_clk_i) disable iff (!rst_ni)
    (irq_mode_i != IRQ_FRAME) |=> !irq_o);
endmodule

bind fsx_frame_sync_sel fsx_frame_sync_sel_chk u_chk (
  .bclk_i     (bclk_i),
  .cpu_clk_i  (cpu_clk_i),
  .rst_ni     (rst_ni),
  .mode_int_i (mode_int_i),
  .gen_sel_i  (gen_sel_i),
  .fgen_rst_ni(fgen_rst_ni),
  .pol_i      (pol_i),
  .pad_o      (pad_o),
  .copy_req_i (copy_req_i),
  .copy_pulse (copy_pulse),
  .irq_mode_i (irq_mode_i),
  .irq_o      (irq_o)
);

// File: tb/test_fsx_frame_sync_sel.sv
module test_fsx_frame_sync_sel;
  logic bclk = 1'b0, cpu_clk = 1'b0, rst_ni = 1'b0;
  logic tx_rst_ni = 1'b0, fgen_rst_ni = 1'b1, mode_int = 1'b0, gen_sel = 1'b0, pol = 1'b0;
  logic [1:0] irq_mode = 2'b00;
  logic pad_i = 1'b0, gen_fs = 1'b0, copy_req = 1'b0;
  logic pad_o, pad_oe, fs_tx, irq;

  int n_chk = 0, n_err = 0, irq_cnt = 0;

  always #5  cpu_clk = ~cpu_clk;   // 100 MHz
  always #20 bclk    = ~bclk;

  fsx_frame_sync_sel i_fsx_frame_sync_sel (
    .bclk_i(bclk), .cpu_clk_i(cpu_clk), .rst_ni(rst_ni), .tx_rst_ni(tx_rst_ni),
    .fgen_rst_ni(fgen_rst_ni), .mode_int_i(mode_int), .gen_sel_i(gen_sel), .pol_i(pol),
    .irq_mode_i(irq_mode), .pad_i(pad_i), .gen_fs_i(gen_fs), .copy_req_i(copy_req),
    .pad_o(pad_o), .pad_oe_o(pad_oe), .fs_tx_o(fs_tx), .irq_o(irq)
  );

  always @(negedge cpu_clk) if (irq) irq_cnt++;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  // kind 0: pad, 1: generator, 2: copy request; each frame is 1 active + 3 idle bit clocks
  task automatic frames(input int n, input int kind);
    for (int f = 0; f < n; f++) begin
      @(negedge bclk);
      if (kind == 0) pad_i = ~pol;
      else if (kind == 1) gen_fs = 1'b1;
      else copy_req = 1'b1;
      @(negedge bclk);
      pad_i = pol; gen_fs = 1'b0; copy_req = 1'b0;
      repeat (2) @(negedge bclk);
    end
  endtask

  task automatic irq_run(input string req, input int kind, input int n, input int exp);
    pad_i = pol; gen_fs = 1'b0; copy_req = 1'b0;
    repeat (6) @(negedge bclk);
    irq_cnt = 0;
    frames(n, kind);
    repeat (4) @(negedge bclk);
    check(req, irq_cnt, exp);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
  end

  initial begin
    // R10: reset state with a pending copy request
    mode_int = 1'b1; gen_sel = 1'b0; copy_req = 1'b1; tx_rst_ni = 1'b1;
    repeat (3) @(negedge bclk);
    check("R10 fs_tx in reset", fs_tx, 0);
    check("R10 irq in reset", irq, 0);
    copy_req = 1'b0;
    @(negedge bclk); rst_ni = 1'b1;
    repeat (2) @(negedge bclk);
    check("R10 no pulse after reset", fs_tx, 0);

    // R1 R2 R3 R6: exhaustive static sweep, copy pulse idle
    for (int v = 0; v < 128; v++) begin
      @(negedge bclk);
      {tx_rst_ni, mode_int, gen_sel, pol, pad_i, gen_fs, fgen_rst_ni} = v[6:0];
      #2;
      begin
        int sel, e_tx, e_pad, e_oe;
        sel   = mode_int ? (gen_sel ? int'(gen_fs & fgen_rst_ni) : 0) : int'(pad_i ^ pol);
        e_tx  = sel & int'(tx_rst_ni);
        e_oe  = int'(mode_int);
        e_pad = mode_int ? (sel ^ int'(pol)) : 0;
        if (!mode_int) begin
          check("R1 oe", pad_oe, e_oe); check("R1 pad_o", pad_o, e_pad);
        end else if (gen_sel && fgen_rst_ni) begin
          check("R2 oe", pad_oe, e_oe); check("R2 pad_o", pad_o, e_pad);
        end else if (gen_sel) begin
          check("R3 pad_o", pad_o, e_pad);
        end else begin
          check("R4 oe idle", pad_oe, e_oe); check("R4 pad_o idle", pad_o, e_pad);
        end
        check("R6 fs_tx", fs_tx, e_tx);
      end
    end

    // R4 R5: copy pulse, single and back-to-back, both polarities
    for (int p = 0; p < 2; p++) begin
      @(negedge bclk);
      tx_rst_ni = 1'b1; mode_int = 1'b1; gen_sel = 1'b0; pol = p[0];
      repeat (3) @(negedge bclk);
      copy_req = 1'b1;
      @(negedge bclk); copy_req = 1'b0;
      check("R4 pulse", fs_tx, 1); check("R4 pad", pad_o, 1 ^ p);
      @(negedge bclk);
      check("R4 one period", fs_tx, 0); check("R4 pad idle", pad_o, p);
      copy_req = 1'b1;
      @(negedge bclk); check("R5 first", fs_tx, 1);
      @(negedge bclk); check("R5 gap", fs_tx, 0); copy_req = 1'b0;
      @(negedge bclk); check("R5 queued", fs_tx, 1);
      @(negedge bclk); check("R5 end", fs_tx, 0);
    end

    // R7: frame-detect interrupts per source and polarity
    irq_mode = 2'b10; tx_rst_ni = 1'b1; fgen_rst_ni = 1'b1;
    mode_int = 1'b0; pol = 1'b0; irq_run("R7 pad pol0", 0, 5, 5);
    pol = 1'b1;                  irq_run("R7 pad pol1", 0, 4, 4);
    mode_int = 1'b1; gen_sel = 1'b1; irq_run("R7 gen", 1, 6, 6);
    fgen_rst_ni = 1'b0;          irq_run("R3 gen off irq", 1, 3, 0);
    fgen_rst_ni = 1'b1; gen_sel = 1'b0; irq_run("R7 copy", 2, 3, 3);

    // R8: other interrupt modes stay silent
    mode_int = 1'b0; pol = 1'b0;
    irq_mode = 2'b00; irq_run("R8 mode00", 0, 3, 0);
    irq_mode = 2'b01; irq_run("R8 mode01", 0, 3, 0);
    irq_mode = 2'b11; irq_run("R8 mode11", 0, 3, 0);

    // R9: interrupts while transmitter is held in reset
    irq_mode = 2'b10; tx_rst_ni = 1'b0;
    pol = 1'b1; irq_run("R9 pad pol1", 0, 4, 4);
    check("R9 fs_tx held", fs_tx, 0);
    mode_int = 1'b1; gen_sel = 1'b1; irq_run("R9 gen", 1, 3, 3);
    gen_sel = 1'b0; irq_run("R9 copy", 2, 2, 2);

    summary();
  end
endmodule